// File: doc/BRIEF.md
# Serial Peripheral Register Slave

This block is the bus-facing register file of a serial peripheral controller. It sits on a Wishbone-style pipelined slave port with a 32-bit address and data bus and four byte-enable lanes. It decodes four word registers at the bottom of its address window: a status word, a control word, a receive word and a transmit word. Every strobe inside a bus cycle is answered with a one-clock acknowledge, and read data is returned in that same clock. The stall output never asserts, because every access finishes in fixed time.

The control word carries a 16-bit clock divider, which sets the serial rate to f_clk / (2 * divider), and an active-high device-select bit. Both are brought out as ports for the serial engine. Writing a byte to the transmit word launches a transfer on a separate shift engine through a start/done handshake. The status word shows whether the transmit slot is free. When the engine reports that a transfer has finished, it hands back the byte it received. That byte can be read once from the receive word and is then wiped.

Top module: `spi_regif`

## Requirements
- R1: While rst_n is low at a rising edge, every register returns to its initial state. After reset, the control word and the receive word read 0, the status word reads 0x0000_0001 (transmit slot free) and eng_start is low.
- R2: Each rising edge at which s_cyc and s_stb are both high produces s_ack high for exactly the following clock. A strobe with s_cyc low produces no acknowledge. s_stall is always low.
- R3: The control word (offset 0x4) keeps the divider in bits 31..16 and the select in bit 0. Bits 15..1 read 0. A write updates byte k (bits 8k+7..8k) only when s_sel[k] is 1. ctl_prescale and ctl_select show the stored fields.
- R4: The status word (offset 0x0) has bit 0 = 1 when the transmit slot is free and 0 while a byte is in flight. Bits 31..1 read 0.
- R5: A write to offset 0xC with s_sel[0]=1 while the slot is free gives a one-clock eng_start pulse, one clock after the strobe, with eng_tx_byte equal to write-data bits 7..0. It also clears status bit 0, which stays 0 until an eng_done pulse sets it back to 1.
- R6: A write to offset 0xC while status bit 0 is 0, or with s_sel[0]=0, starts nothing and changes no register.
- R7: An eng_done pulse stores eng_rx_byte. A read of offset 0x8 returns it in bits 7..0 with bits 31..8 at 0, and the stored byte is 0 for every later read until the next eng_done.
- R8: If a read of offset 0x8 and an eng_done pulse fall on the same edge, the read returns the old byte and the new byte is kept for the next read.
- R9: Reads of offset 0xC, and any access whose address is not 0x0, 0x4, 0x8 or 0xC, are acknowledged and return 0. Writes to such addresses, and writes to offsets 0x0 and 0x8, change nothing. s_rdata is 0 in every clock without an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_cyc | input | 1 | Bus cycle in progress |
| s_stb | input | 1 | Transfer request, qualified by s_cyc |
| s_we | input | 1 | 1 for write, 0 for read |
| s_addr | input | 32 | Byte address |
| s_wdata | input | 32 | Write data |
| s_sel | input | 4 | Byte-lane enables |
| s_rdata | output | 32 | Read data, valid with s_ack |
| s_ack | output | 1 | One-clock acknowledge |
| s_stall | output | 1 | Back-pressure, held low |
| ctl_prescale | output | 16 | Serial clock divider field |
| ctl_select | output | 1 | Device-select field |
| eng_start | output | 1 | One-clock launch pulse to the shift engine |
| eng_tx_byte | output | 8 | Byte to transmit, held from launch |
| eng_done | input | 1 | One-clock completion pulse from the engine |
| eng_rx_byte | input | 8 | Byte received, valid with eng_done |

## Verification
Two functions can meet on one edge: the clear that follows a bus read of the receive word, and the engine's completion pulse that loads a new byte into it. The bench provokes this by raising the read strobe and eng_done in the same clock. The read must return the previous byte, and a second read must return the newly delivered one, which shows that the load wins over the clear. A transmit write that arrives while the slot is busy is also checked, so that the guard against overwriting is seen at eng_start.

// File: rtl/spi_regif_pkg.sv
// Package: shared register index type and decoded request record.
// Assumes a word-addressed window of four registers at offset 0.
package spi_regif_pkg;

    typedef enum logic [1:0] {
        IDX_STATUS  = 2'd0,
        IDX_CONTROL = 2'd1,
        IDX_RXWORD  = 2'd2,
        IDX_TXWORD  = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic     valid;   // qualified strobe this clock
        logic     write;   // direction
        logic     mapped;  // address lands on one of the four words
        reg_idx_e idx;     // which word
    } bus_req_t;

endpackage

// File: rtl/regif_decode.sv
// Module: regif_decode
// Turns the raw bus strobe and address into a decoded request.
// Assumes: registers sit at word offsets 0..3 of a window based at 0;
// any other address bit set, including the two lowest, is unmapped.
module regif_decode
    import spi_regif_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              cyc,
    input  logic              stb,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output bus_req_t          req
);
    localparam int IDX_LSB = 2;
    localparam int IDX_MSB = 3;

    // Purpose: qualify the strobe and classify the address.
    always_comb begin
        req.valid  = cyc & stb;
        req.write  = we;
        req.mapped = (addr[ADDR_W-1:IDX_MSB+1] == '0) && (addr[IDX_LSB-1:0] == '0);
        req.idx    = reg_idx_e'(addr[IDX_MSB:IDX_LSB]);
    end

endmodule

// File: rtl/regif_ctrl_reg.sv
// Module: regif_ctrl_reg
// Control word storage with per-byte-lane write enables.
// Assumes: divider occupies the top PRESC_W bits, select is bit 0,
// every other bit is read-only zero.
module regif_ctrl_reg #(
    parameter int DATA_W  = 32,
    parameter int PRESC_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [DATA_W/8-1:0]  be,
    output logic [DATA_W-1:0]    word,
    output logic [PRESC_W-1:0]   prescale,
    output logic                 select
);
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;
    localparam logic [DATA_W-1:0] WMASK =
        {{PRESC_W{1'b1}}, {(DATA_W-PRESC_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] word_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Purpose: update one byte lane when it is enabled.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q[g*LANE_W +: LANE_W] <= '0;
            else if (wr_en && be[g])
                word_q[g*LANE_W +: LANE_W] <= wdata[g*LANE_W +: LANE_W] & WMASK[g*LANE_W +: LANE_W];
        end
    end

    assign word     = word_q;
    assign prescale = word_q[DATA_W-1 -: PRESC_W];
    assign select   = word_q[0];

endmodule

// File: rtl/regif_xfer.sv
// Module: regif_xfer
// Transmit slot, launch pulse and receive byte holder.
// Assumes: the engine raises done for one clock per launched byte;
// a completion load takes priority over a read-clear on the same edge.
module regif_xfer #(
    parameter int SER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_wr,
    input  logic [SER_W-1:0] tx_byte,
    input  logic             rx_rd,
    input  logic             eng_done,
    input  logic [SER_W-1:0] eng_rx_byte,
    output logic             txe,
    output logic [SER_W-1:0] rx_byte,
    output logic             eng_start,
    output logic [SER_W-1:0] eng_tx_byte
);
    logic             txe_q;
    logic [SER_W-1:0] rx_q;
    logic             start_q;
    logic [SER_W-1:0] txb_q;
    logic             launch;

    assign launch = tx_wr & txe_q;

    // Purpose: track whether the transmit slot is free.
    always_ff @(posedge clk) begin
        if (!rst_n)        txe_q <= 1'b1;
        else if (launch)   txe_q <= 1'b0;
        else if (eng_done) txe_q <= 1'b1;
    end

    // Purpose: issue a one-clock start and hold the byte being sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            txb_q   <= '0;
        end else begin
            start_q <= launch;
            if (launch) txb_q <= tx_byte;
        end
    end

    // Purpose: capture the received byte; wipe it after a read.
    always_ff @(posedge clk) begin
        if (!rst_n)        rx_q <= '0;
        else if (eng_done) rx_q <= eng_rx_byte;
        else if (rx_rd)    rx_q <= '0;
    end

    assign txe         = txe_q;
    assign rx_byte     = rx_q;
    assign eng_start   = start_q;
    assign eng_tx_byte = txb_q;

endmodule

// File: rtl/spi_regif.sv
// Module: spi_regif (top)
// Bus slave for the serial peripheral: decodes, stores control, launches
// transmits and returns read data with a registered one-clock acknowledge.
// Assumes: single clock domain, no back-pressure needed.
module spi_regif
    import spi_regif_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int PRESC_W = 16,
    parameter int SER_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_cyc,
    input  logic                 s_stb,
    input  logic                 s_we,
    input  logic [ADDR_W-1:0]    s_addr,
    input  logic [DATA_W-1:0]    s_wdata,
    input  logic [DATA_W/8-1:0]  s_sel,
    output logic [DATA_W-1:0]    s_rdata,
    output logic                 s_ack,
    output logic                 s_stall,
    output logic [PRESC_W-1:0]   ctl_prescale,
    output logic                 ctl_select,
    output logic                 eng_start,
    output logic [SER_W-1:0]     eng_tx_byte,
    input  logic                 eng_done,
    input  logic [SER_W-1:0]     eng_rx_byte
);
    bus_req_t          req;
    logic [DATA_W-1:0] ctrl_word;
    logic              txe;
    logic [SER_W-1:0]  rx_byte;
    logic              wr_hit, rd_hit;
    logic              ctrl_wr, tx_wr, rx_rd;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic              ack_q;

    regif_decode #(.ADDR_W(ADDR_W)) u_decode (
        .cyc (s_cyc),
        .stb (s_stb),
        .we  (s_we),
        .addr(s_addr),
        .req (req)
    );

    // Purpose: derive per-register write and read strobes.
    always_comb begin
        wr_hit  = req.valid & req.mapped & req.write;
        rd_hit  = req.valid & req.mapped & ~req.write;
        ctrl_wr = wr_hit & (req.idx == IDX_CONTROL);
        tx_wr   = wr_hit & (req.idx == IDX_TXWORD) & s_sel[0];
        rx_rd   = rd_hit & (req.idx == IDX_RXWORD);
    end

    regif_ctrl_reg #(.DATA_W(DATA_W), .PRESC_W(PRESC_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_wr),
        .wdata   (s_wdata),
        .be      (s_sel),
        .word    (ctrl_word),
        .prescale(ctl_prescale),
        .select  (ctl_select)
    );

    regif_xfer #(.SER_W(SER_W)) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_wr      (tx_wr),
        .tx_byte    (s_wdata[SER_W-1:0]),
        .rx_rd      (rx_rd),
        .eng_done   (eng_done),
        .eng_rx_byte(eng_rx_byte),
        .txe        (txe),
        .rx_byte    (rx_byte),
        .eng_start  (eng_start),
        .eng_tx_byte(eng_tx_byte)
    );

    // Purpose: select the read value; unmapped and write-only words give zero.
    always_comb begin
        rd_mux = '0;
        if (rd_hit) begin
            unique case (req.idx)
                IDX_STATUS:  rd_mux = {{(DATA_W-1){1'b0}}, txe};
                IDX_CONTROL: rd_mux = ctrl_word;
                IDX_RXWORD:  rd_mux = {{(DATA_W-SER_W){1'b0}}, rx_byte};
                IDX_TXWORD:  rd_mux = '0;
            endcase
        end
    end

    // Purpose: register the acknowledge and the read data together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q   <= req.valid;
            rdata_q <= rd_mux;
        end
    end

    assign s_ack   = ack_q;
    assign s_rdata = rdata_q;
    assign s_stall = 1'b0;

endmodule

// File: rtl/spi_regif_checker.sv
// Module: spi_regif_checker
// Temporal properties of the register slave, bound into spi_regif.
module spi_regif_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_cyc,
    input logic              s_stb,
    input logic              s_we,
    input logic              s_ack,
    input logic [DATA_W-1:0] s_rdata,
    input logic              ctl_select,
    input logic              eng_start,
    input logic              txe
);
    AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_cyc && s_stb) |=> s_ack);                                 // R2
    AST_ACK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_cyc && s_stb) |=> !s_ack);                               // R2
    AST_SELECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_cyc && s_stb && s_we) |=> $stable(ctl_select));          // R3
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);                                   // R5
    AST_START_CLEARS_TXE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !txe);                                         // R5
    AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !txe |=> !eng_start);                                        // R6
    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !s_ack |-> (s_rdata == '0));                                 // R9
endmodule

bind spi_regif spi_regif_checker #(.DATA_W(DATA_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_cyc     (s_cyc),
    .s_stb     (s_stb),
    .s_we      (s_we),
    .s_ack     (s_ack),
    .s_rdata   (s_rdata),
    .ctl_select(ctl_select),
    .eng_start (eng_start),
    .txe       (txe)
);

// File: tb/test_spi_regif.sv
// Directed bench: one task per scenario, each checking its own results.
module test_spi_regif;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        s_cyc, s_stb, s_we;
    logic [31:0] s_addr, s_wdata, s_rdata;
    logic [3:0]  s_sel;
    logic        s_ack, s_stall;
    logic [15:0] ctl_prescale;
    logic        ctl_select;
    logic        eng_start;
    logic [7:0]  eng_tx_byte;
    logic        eng_done;
    logic [7:0]  eng_rx_byte;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regif i_spi_regif (
        .clk(clk), .rst_n(rst_n),
        .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_addr(s_addr),
        .s_wdata(s_wdata), .s_sel(s_sel), .s_rdata(s_rdata), .s_ack(s_ack),
        .s_stall(s_stall), .ctl_prescale(ctl_prescale), .ctl_select(ctl_select),
        .eng_start(eng_start), .eng_tx_byte(eng_tx_byte),
        .eng_done(eng_done), .eng_rx_byte(eng_rx_byte)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One bus access; returns read data and whether a launch pulse followed.
    task automatic bus(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                       input logic [3:0] sel, output logic [31:0] rd, output logic started);
        @(negedge clk);
        s_cyc = 1'b1; s_stb = 1'b1; s_we = we; s_addr = addr; s_wdata = wd; s_sel = sel;
        @(posedge clk);
        @(negedge clk);
        check("R2 ack", {31'd0, s_ack}, 32'd1);
        rd = s_rdata;
        started = eng_start;
        s_cyc = 1'b0; s_stb = 1'b0; s_we = 1'b0;
    endtask

    task automatic rd_word(input logic [31:0] addr, output logic [31:0] rd);
        logic st;
        bus(1'b0, addr, 32'd0, 4'hF, rd, st);
    endtask

    task automatic engine_finish(input logic [7:0] b);
        @(negedge clk);
        eng_done = 1'b1; eng_rx_byte = b;
        @(posedge clk);
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] rd;
        check("R1 start", {31'd0, eng_start}, 32'd0);
        rd_word(32'h0, rd); check("R1 R4 status", rd, 32'h1);
        rd_word(32'h4, rd); check("R1 control", rd, 32'h0);
        rd_word(32'h8, rd); check("R1 rx", rd, 32'h0);
    endtask

    task automatic t_ack;
        logic [31:0] rd;
        rd_word(32'h0, rd);
        @(negedge clk);
        check("R2 single pulse", {31'd0, s_ack}, 32'd0);
        s_cyc = 1'b0; s_stb = 1'b1; s_addr = 32'h0;
        @(posedge clk);
        @(negedge clk);
        check("R2 no cyc", {31'd0, s_ack}, 32'd0);
        check("R2 stall", {31'd0, s_stall}, 32'd0);
        s_stb = 1'b0;
    endtask

    task automatic t_control;
        logic [31:0] rd; logic st;
        bus(1'b1, 32'h4, 32'hABCD_FFFF, 4'hF, rd, st);
        rd_word(32'h4, rd); check("R3 full write", rd, 32'hABCD_0001);
        check("R3 prescale port", {16'd0, ctl_prescale}, 32'h0000_ABCD);
        check("R3 select port", {31'd0, ctl_select}, 32'd1);
        bus(1'b1, 32'h4, 32'h1234_0000, 4'b1000, rd, st);
        rd_word(32'h4, rd); check("R3 lane 3 only", rd, 32'h12CD_0001);
        bus(1'b1, 32'h4, 32'h0000_0000, 4'b0001, rd, st);
        rd_word(32'h4, rd); check("R3 lane 0 only", rd, 32'h12CD_0000);
        check("R3 select cleared", {31'd0, ctl_select}, 32'd0);
    endtask

    task automatic t_transmit;
        logic [31:0] rd; logic st;
        bus(1'b1, 32'hC, 32'hFFFF_FFA5, 4'b0001, rd, st);
        check("R5 start pulse", {31'd0, st}, 32'd1);
        check("R5 tx byte", {24'd0, eng_tx_byte}, 32'hA5);
        @(negedge clk);
        check("R5 start one clock", {31'd0, eng_start}, 32'd0);
        rd_word(32'h0, rd); check("R5 R4 busy status", rd, 32'h0);
        bus(1'b1, 32'hC, 32'h0000_003C, 4'b0001, rd, st);
        check("R6 busy write no start", {31'd0, st}, 32'd0);
        check("R6 byte kept", {24'd0, eng_tx_byte}, 32'hA5);
        engine_finish(8'h5A);
        rd_word(32'h0, rd); check("R5 free after done", rd, 32'h1);
        bus(1'b1, 32'hC, 32'h0000_7700, 4'b0010, rd, st);
        check("R6 lane0 off no start", {31'd0, st}, 32'd0);
        rd_word(32'h0, rd); check("R6 status unchanged", rd, 32'h1);
    endtask

    task automatic t_receive;
        logic [31:0] rd;
        rd_word(32'h8, rd); check("R7 rx byte", rd, 32'h5A);
        rd_word(32'h8, rd); check("R7 cleared on read", rd, 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] rd; logic st;
        bus(1'b1, 32'hC, 32'h11, 4'b0001, rd, st);
        engine_finish(8'h11);
        @(negedge clk);
        s_cyc = 1'b1; s_stb = 1'b1; s_we = 1'b0; s_addr = 32'h8; s_sel = 4'hF;
        eng_done = 1'b1; eng_rx_byte = 8'h77;
        @(posedge clk);
        @(negedge clk);
        check("R8 read returns old", s_rdata, 32'h11);
        s_cyc = 1'b0; s_stb = 1'b0; eng_done = 1'b0;
        rd_word(32'h8, rd); check("R8 new byte kept", rd, 32'h77);
    endtask

    task automatic t_unmapped;
        logic [31:0] rd; logic st;
        rd_word(32'hC, rd);  check("R9 tx word reads zero", rd, 32'h0);
        rd_word(32'h10, rd); check("R9 unmapped read", rd, 32'h0);
        bus(1'b1, 32'h14, 32'hFFFF_FFFF, 4'hF, rd, st);
        check("R9 unmapped write no start", {31'd0, st}, 32'd0);
        rd_word(32'h4, rd);  check("R9 control untouched", rd, 32'h12CD_0000);
        bus(1'b1, 32'h0, 32'h0, 4'hF, rd, st);
        rd_word(32'h0, rd);  check("R9 status write ignored", rd, 32'h1);
        bus(1'b1, 32'h8, 32'hFF, 4'hF, rd, st);
        rd_word(32'h8, rd);  check("R9 rx write ignored", rd, 32'h0);
    endtask

    initial begin
        s_cyc = 0; s_stb = 0; s_we = 0; s_addr = 0; s_wdata = 0; s_sel = 0;
        eng_done = 0; eng_rx_byte = 0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ack();
        t_control();
        t_transmit();
        t_receive();
        t_collide();
        t_unmapped();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule